// File: doc/BRIEF.md
# Interrupt Controller with Wake Logic

This block gathers up to 32 single-cycle request pulses from peripherals into a latched flag register. It decides whether a processor core should take an interrupt, and whether a halted core should be released. Software reaches it through a narrow register port. The 32-bit enable and flag registers are each split into a low half and a high half, and the port also holds a one-bit global master switch.

Two outputs leave the block. The pending-interrupt level is registered, and it is high only when the master switch is on and at least one enabled flag is set. A one-cycle wake pulse is raised whenever an enabled source fires, even with the master switch off, so a sleeping core resumes and can poll. The core's own interrupt-disable bit gates the line that actually reaches the core. The flags stay latched, so a masked interrupt is still delivered once the bit clears. Software acknowledges a flag by writing 1 to that bit.

Top module: `irq_wake_ctl`

## Requirements
- R1: After reset, every register reads 0, and `irq_pending`, `irq_core` and `wake` are 0.
- R2: A pulse on source s sets a flag bit. For s < 16 it is bit s of the low flag half (select 3). For s >= 16 it is bit s-16 of the high flag half (select 4). Register selects: 0 master, 1 enable low, 2 enable high, 3 flag low, 4 flag high.
- R3: A write to a flag half clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a source fires in the same cycle that software clears its flag bit, the flag stays set.
- R5: `irq_pending` is 1 in the cycle after the master switch is on and some enable bit and its flag bit are both set, in either half.
- R6: While the master switch is off, `irq_pending` is 0 from the next cycle on, and the flags are kept.
- R7: An enable write, or a nonzero master write, that exposes an already pending flag raises `irq_pending` on the cycle after the register updates, with no new request needed.
- R8: `irq_pending` drops in the cycle after the last enabled flag is cleared.
- R9: `wake` pulses for one cycle, the cycle after an enabled source fires, whatever the master switch holds. A source whose enable bit is clear never causes a wake.
- R10: `irq_core` equals `irq_pending` while `core_irq_disable` is 0 and is 0 while it is 1. The pending state is kept and is delivered once the disable bit drops.
- R11: An enable write stores all 16 data bits. A master write stores 1 for any nonzero value and 0 for zero, and reads back as 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Single-cycle request pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Write register select |
| reg_wdata | input | 16 | Write data |
| reg_rsel | input | 3 | Read register select |
| reg_rdata | output | 16 | Read data for `reg_rsel`, combinational |
| core_irq_disable | input | 1 | The core's interrupt-disable bit |
| irq_pending | output | 1 | Registered interrupt-pending level |
| irq_core | output | 1 | Interrupt line delivered to the core |
| wake | output | 1 | One-cycle release pulse for a halted core |

## Verification
The bench targets the difference between waking and interrupting. An enabled request that arrives with the master switch off must produce a wake pulse and must not raise an interrupt. A design that tied wake to the master switch would leave a sleeping core asleep. The bench also drives a same-cycle request and acknowledge on one bit: a design where the clear wins would silently drop an event. It writes zeros to a flag half, which would wipe pending work in a design that stored the value instead of acknowledging. It sets a flag first and enables it afterwards, which exposes any design that only looks at new requests. It holds the core's disable bit across a pending interrupt to check that the interrupt is kept rather than lost.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   typedef enum logic [2:0] {
      SEL_MASTER  = 3'd0,
      SEL_EN_LO   = 3'd1,
      SEL_EN_HI   = 3'd2,
      SEL_FLAG_LO = 3'd3,
      SEL_FLAG_HI = 3'd4
   } reg_sel_e;

   localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/irq_half_bank.sv
module irq_half_bank #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req_i,
   input  logic         en_we,
   input  logic         flag_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en_q,
   output logic [W-1:0] flag_q
);

   logic [W-1:0] clr_mask;

   assign clr_mask = flag_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         flag_q <= '0;
      end else begin
         if (en_we) en_q <= wdata;
         flag_q <= (flag_q & ~clr_mask) | req_i;
      end
   end

   assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |=> ((flag_q & $past(req_i)) == $past(req_i)));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> ((flag_q & $past(wdata & ~req_i)) == '0));

   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flag_q) & ~$past(clr_mask)) & ~flag_q) == '0));

   assert_req_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && |(req_i & wdata)) |=>
      ((flag_q & $past(req_i & wdata)) == $past(req_i & wdata)));

endmodule

// File: rtl/irq_eval.sv
module irq_eval #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         master_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] flag_i,
   input  logic [N-1:0] req_i,
   input  logic         irq_disable_i,
   output logic         irq_q,
   output logic         irq_core_o,
   output logic         wake_q
);

   logic any_active;
   logic any_wake;

   assign any_active = |(en_i & flag_i);
   assign any_wake   = |(en_i & req_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         irq_q  <= master_i & any_active;
         wake_q <= any_wake;
      end
   end

   assign irq_core_o = irq_q & ~irq_disable_i;

endmodule

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl #(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned NSRC   = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_req,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [HALF_W-1:0] reg_wdata,
   input  logic [2:0]        reg_rsel,
   output logic [HALF_W-1:0] reg_rdata,
   input  logic              core_irq_disable,
   output logic              irq_pending,
   output logic              irq_core,
   output logic              wake
);
   import irq_ctl_pkg::*;

   localparam int unsigned HALVES = NUM_HALVES;

   if (HALF_W < 1 || HALF_W > 32) begin : g_bad_width
      $error("irq_wake_ctl: HALF_W out of range");
   end
   if (NSRC != HALVES * HALF_W) begin : g_bad_count
      $error("irq_wake_ctl: NSRC must be two halves");
   end

   logic              master_q;
   logic [NSRC-1:0]   en_all;
   logic [NSRC-1:0]   flag_all;

   always_ff @(posedge clk) begin
      if (!rst_n)                                   master_q <= 1'b0;
      else if (reg_we && reg_sel == 3'(SEL_MASTER)) master_q <= |reg_wdata;
   end

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic en_we_h;
      logic flag_we_h;
      assign en_we_h   = reg_we && (reg_sel == (h == 0 ? 3'(SEL_EN_LO)   : 3'(SEL_EN_HI)));
      assign flag_we_h = reg_we && (reg_sel == (h == 0 ? 3'(SEL_FLAG_LO) : 3'(SEL_FLAG_HI)));
      irq_half_bank #(.W(HALF_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .req_i   (src_req[h*HALF_W +: HALF_W]),
         .en_we   (en_we_h),
         .flag_we (flag_we_h),
         .wdata   (reg_wdata),
         .en_q    (en_all[h*HALF_W +: HALF_W]),
         .flag_q  (flag_all[h*HALF_W +: HALF_W])
      );
   end

   irq_eval #(.N(NSRC)) u_eval (
      .clk           (clk),
      .rst_n         (rst_n),
      .master_i      (master_q),
      .en_i          (en_all),
      .flag_i        (flag_all),
      .req_i         (src_req),
      .irq_disable_i (core_irq_disable),
      .irq_q         (irq_pending),
      .irq_core_o    (irq_core),
      .wake_q        (wake)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_rsel)
         3'(SEL_MASTER):  reg_rdata = HALF_W'(master_q);
         3'(SEL_EN_LO):   reg_rdata = en_all[0 +: HALF_W];
         3'(SEL_EN_HI):   reg_rdata = en_all[HALF_W +: HALF_W];
         3'(SEL_FLAG_LO): reg_rdata = flag_all[0 +: HALF_W];
         3'(SEL_FLAG_HI): reg_rdata = flag_all[HALF_W +: HALF_W];
         default:         reg_rdata = '0;
      endcase
   end

   assert_master_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !master_q |=> !irq_pending);

   assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_all & flag_all) == '0) |=> !irq_pending);

   assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(|src_req));

endmodule

// File: tb/irq_wake_ctl_test.sv
`timescale 1ns/1ps
module irq_wake_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_req = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic [2:0]  reg_rsel = '0;
   logic [15:0] reg_rdata;
   logic        core_irq_disable = 1'b0;
   logic        irq_pending, irq_core, wake;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_wake_ctl uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
      .reg_rdata(reg_rdata), .core_irq_disable(core_irq_disable),
      .irq_pending(irq_pending), .irq_core(irq_core), .wake(wake)
   );

   typedef struct packed {
      logic        we;
      logic [2:0]  sel;
      logic [15:0] wdata;
      logic [31:0] req;
      logic        dis;
      logic [2:0]  rsel;
      logic [15:0] exp_rd;
      logic        exp_irq;
      logic        exp_core;
      logic        exp_wake;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'd0, 16'h0001, 32'h0,        1'b0, 3'd0, 16'h0001, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 master on
      '{1'b0, 3'd0, 16'h0000, 32'h00000008, 1'b0, 3'd3, 16'h0008, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 R2 no wake when disabled
      '{1'b1, 3'd1, 16'h0008, 32'h0,        1'b0, 3'd1, 16'h0008, 1'b0, 1'b0, 1'b0, 4'd11}, // enable low bit 3
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd3, 16'h0008, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 enable exposes pending
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b1, 3'd3, 16'h0008, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 gated, kept
      '{1'b1, 3'd3, 16'h0008, 32'h0,        1'b0, 3'd3, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 ack
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 drop
      '{1'b0, 3'd0, 16'h0000, 32'h00100000, 1'b0, 3'd4, 16'h0010, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 source 20
      '{1'b1, 3'd2, 16'h0010, 32'h0,        1'b0, 3'd2, 16'h0010, 1'b0, 1'b0, 1'b0, 4'd11},
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h0010, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 high half
      '{1'b1, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd11}, // master off
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h0010, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 no irq, flag kept
      '{1'b0, 3'd0, 16'h0000, 32'h00100000, 1'b0, 3'd4, 16'h0010, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 wake w/o master
      '{1'b1, 3'd0, 16'h0100, 32'h0,        1'b0, 3'd0, 16'h0001, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 nonzero->1
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h0010, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 master write
      '{1'b1, 3'd4, 16'h0010, 32'h00100000, 1'b0, 3'd4, 16'h0010, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 req beats clear
      '{1'b1, 3'd4, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h0010, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 zero no effect
      '{1'b1, 3'd4, 16'hFFFF, 32'h0,        1'b0, 3'd4, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 clear all
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 3'd0, 16'h0000, 32'h80000001, 1'b0, 3'd3, 16'h0001, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 edges
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h8000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 source 31
      '{1'b1, 3'd2, 16'hFFFF, 32'h0,        1'b0, 3'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 all bits
      '{1'b0, 3'd0, 16'h0000, 32'h0,        1'b0, 3'd4, 16'h8000, 1'b1, 1'b1, 1'b0, 4'd5}   // R5 bit 31
   };

   task automatic check(input string what, input int rq, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic check_reset_state(input int rq);
      for (int s = 0; s < 5; s++) begin
         reg_rsel = 3'(s);
         #0.1;
         check("reset reg", rq, reg_rdata, 16'h0);
      end
      check("reset irq_pending", rq, 16'(irq_pending), 16'h0);
      check("reset irq_core", rq, 16'(irq_core), 16'h0);
      check("reset wake", rq, 16'(wake), 16'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL R1 watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_reset_state(1); // R1
      for (int i = 0; i < NV; i++) begin
         reg_we = VEC[i].we;
         reg_sel = VEC[i].sel;
         reg_wdata = VEC[i].wdata;
         src_req = VEC[i].req;
         core_irq_disable = VEC[i].dis;
         reg_rsel = VEC[i].rsel;
         @(posedge clk);
         @(negedge clk);
         reg_we = 1'b0;
         src_req = '0;
         #0.1;
         check("rdata", VEC[i].rq, reg_rdata, VEC[i].exp_rd);
         check("irq_pending", VEC[i].rq, 16'(irq_pending), 16'(VEC[i].exp_irq));
         check("irq_core", VEC[i].rq, 16'(irq_core), 16'(VEC[i].exp_core));
         check("wake", VEC[i].rq, 16'(wake), 16'(VEC[i].exp_wake));
      end
      // R9: wake is a single pulse when the request is not repeated
      @(negedge clk);
      check("wake one cycle", 9, 16'(wake), 16'h0);
      // R10: disable raised and dropped again delivers the kept interrupt
      core_irq_disable = 1'b1;
      #0.1;
      check("core masked", 10, 16'(irq_core), 16'h0);
      core_irq_disable = 1'b0;
      #0.1;
      check("core delivered", 10, 16'(irq_core), 16'h1);
      // R1: reset in mid-run clears everything
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_reset_state(1);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule